// File: doc/BRIEF.md
# Branch Misprediction Rollback Unit

This block keeps a checkpoint of the rename map for each branch that is in flight. When rename sees a branch, it asks for a free checkpoint slot. The slot records the live map table and the branch's active-list position, which serves as its tag. The first integer ALU is the only unit that executes branches, so it is the only unit that resolves them. When it reports a misprediction, the unit does three things in the next cycle. It raises a squash mask over active-list positions for every instruction younger than the branch. It drives the saved map back to the rename table. It sends the correct target to fetch.

Age is measured from the active-list head, with wrap-around, so tags that run past the end of the list still compare correctly. Checkpoints taken for branches younger than the mispredicted one are released in the same cycle as the rollback. The mispredicted branch's own slot, and the slot of any correctly predicted branch, are freed only when that branch retires. When every slot is in use, rename must stall.

Top module: `branch_rollback`

## Requirements
- R1: After reset no slot is in use: `alloc_ready` is 1, and `squash_valid`, `restore_valid`, `redirect_valid` and `squash_mask` are 0.
- R2: An accepted allocation (`alloc_valid` with `alloc_ready` high) stores `alloc_tag` and `alloc_map` in a free slot. With all four slots in use, `alloc_ready` is 0 and an allocation request is ignored: its tag cannot later be resolved.
- R3: A mispredicted resolve whose tag matches a slot drives `squash_valid` high for exactly one cycle, in the cycle after the resolve. In that cycle, bit i of `squash_mask` is 1 exactly when active-list position i is younger than the branch and older than `al_tail`. Outside such a cycle the mask is 0.
- R4: In the same cycle as the squash, `restore_valid` is high and `restore_map` equals the map stored when that branch was allocated.
- R5: In the same cycle as the squash, `redirect_valid` is high and `redirect_pc` equals the `resolve_target` given with the resolve.
- R6: A correctly predicted resolve raises none of the three outputs and leaves every slot and its stored map unchanged.
- R7: On a rollback, the slots of branches younger than the mispredicted branch become free in that same cycle. The mispredicted branch keeps its own slot.
- R8: A retire whose tag matches a slot frees that slot. A freed tag no longer triggers a rollback.
- R9: Age is the distance from `al_head` modulo the active-list depth, so comparisons stay correct when tags wrap past the last position.
- R10: An allocation in the same cycle as an accepted mispredicted resolve is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Rename asks for a checkpoint for a branch |
| alloc_tag | input | 5 | Active-list position of the branch |
| alloc_map | input | 48 | Live map table: 8 logical registers of 6 bits, register 0 in bits 5:0 |
| alloc_ready | output | 1 | A free slot exists; when low, rename stalls |
| resolve_valid | input | 1 | ALU1 reports a branch result |
| resolve_tag | input | 5 | Active-list position of the resolved branch |
| resolve_mispred | input | 1 | The prediction was wrong |
| resolve_target | input | 32 | Correct next fetch address |
| retire_valid | input | 1 | A branch is retiring |
| retire_tag | input | 5 | Active-list position of the retiring branch |
| al_head | input | 5 | Position of the oldest active-list entry |
| al_tail | input | 5 | Next free active-list position |
| squash_valid | output | 1 | A rollback is in progress this cycle |
| squash_mask | output | 32 | One bit per active-list position to squash |
| restore_valid | output | 1 | Write `restore_map` into the live map table |
| restore_map | output | 48 | Checkpointed map of the mispredicted branch |
| redirect_valid | output | 1 | Fetch must restart |
| redirect_pc | output | 32 | Restart address |

## Verification
The assertions make four assumptions about the inputs. Resolve and retire tags name live branches. Every branch tag lies between `al_head` and `al_tail` when it is resolved. No allocation arrives for a tag already held. The outputs are checked against the resolve that came one cycle earlier. The directed scenarios keep every tag inside the head-to-tail window, including the scenario where that window wraps past position 31. The only unmatched tags the scenarios use are ones that were deliberately dropped or freed, so that "ignored" can be seen as the absence of a rollback pulse.

// File: rtl/rb_pkg.sv
package rb_pkg;
    // Age comparison against the active-list head: distance from head wraps modulo depth.
    function automatic logic rb_is_younger(input logic [31:0] a,
                                           input logic [31:0] b,
                                           input logic [31:0] head,
                                           input logic [31:0] depth);
        logic [31:0] off_a;
        logic [31:0] off_b;
        off_a = (a - head) & (depth - 32'd1);
        off_b = (b - head) & (depth - 32'd1);
        return off_a > off_b;
    endfunction
endpackage

// File: rtl/rb_tag_match.sv
module rb_tag_match #(
    parameter int N      = 4,
    parameter int TAG_W  = 5,
    parameter int SLOT_W = 2
) (
    input  logic [N-1:0]            vld,
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]        key,
    output logic                    hit,
    output logic [SLOT_W-1:0]       idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vld[i] && tags[i] == key) begin
                hit = 1'b1;
                idx = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/rb_free_pick.sv
module rb_free_pick #(
    parameter int N      = 4,
    parameter int SLOT_W = 2
) (
    input  logic [N-1:0]      vld,
    output logic              any_free,
    output logic [SLOT_W-1:0] idx
);
    always_comb begin
        any_free = 1'b0;
        idx      = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                any_free = 1'b1;
                idx      = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/rb_squash_gen.sv
module rb_squash_gen #(
    parameter int AL_DEPTH = 32,
    parameter int TAG_W    = 5
) (
    input  logic [TAG_W-1:0]    head,
    input  logic [TAG_W-1:0]    tail,
    input  logic [TAG_W-1:0]    btag,
    output logic [AL_DEPTH-1:0] mask
);
    logic [TAG_W-1:0] off_b;
    logic [TAG_W-1:0] off_t;
    assign off_b = btag - head;
    assign off_t = tail - head;

    for (genvar i = 0; i < AL_DEPTH; i++) begin : g_pos
        logic [TAG_W-1:0] off_i;
        assign off_i   = TAG_W'(i) - head;
        assign mask[i] = (off_i > off_b) && (off_i < off_t);
    end
endmodule

// File: rtl/branch_rollback.sv
module branch_rollback #(
    parameter int NUM_CKPT = 4,
    parameter int AL_DEPTH = 32,
    parameter int MAP_REGS = 8,
    parameter int PREG_W   = 6,
    parameter int PC_W     = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   alloc_valid,
    input  logic [$clog2(AL_DEPTH)-1:0]            alloc_tag,
    input  logic [MAP_REGS*PREG_W-1:0]             alloc_map,
    output logic                                   alloc_ready,
    input  logic                                   resolve_valid,
    input  logic [$clog2(AL_DEPTH)-1:0]            resolve_tag,
    input  logic                                   resolve_mispred,
    input  logic [PC_W-1:0]                        resolve_target,
    input  logic                                   retire_valid,
    input  logic [$clog2(AL_DEPTH)-1:0]            retire_tag,
    input  logic [$clog2(AL_DEPTH)-1:0]            al_head,
    input  logic [$clog2(AL_DEPTH)-1:0]            al_tail,
    output logic                                   squash_valid,
    output logic [AL_DEPTH-1:0]                    squash_mask,
    output logic                                   restore_valid,
    output logic [MAP_REGS*PREG_W-1:0]             restore_map,
    output logic                                   redirect_valid,
    output logic [PC_W-1:0]                        redirect_pc
);
    import rb_pkg::*;

    localparam int TAG_W  = $clog2(AL_DEPTH);
    localparam int SLOT_W = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1;
    localparam int MAP_W  = MAP_REGS * PREG_W;

    typedef struct packed {
        logic [NUM_CKPT-1:0]            vld;
        logic [NUM_CKPT-1:0][TAG_W-1:0] tag;
        logic [NUM_CKPT-1:0][MAP_W-1:0] map;
        logic                           sq_v;
        logic [AL_DEPTH-1:0]            sq_mask;
        logic [MAP_W-1:0]               rs_map;
        logic [PC_W-1:0]                rd_pc;
    } rb_state_t;

    rb_state_t st_d, st_q;

    logic              res_hit_w, ret_hit_w, free_any_w;
    logic [SLOT_W-1:0] res_idx_w, ret_idx_w, free_idx_w;
    logic [AL_DEPTH-1:0] mask_w;
    logic [NUM_CKPT-1:0] younger_w;
    logic              rb_fire_w;

    rb_tag_match #(.N(NUM_CKPT), .TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_res_match (
        .vld(st_q.vld), .tags(st_q.tag), .key(resolve_tag),
        .hit(res_hit_w), .idx(res_idx_w)
    );

    rb_tag_match #(.N(NUM_CKPT), .TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_ret_match (
        .vld(st_q.vld), .tags(st_q.tag), .key(retire_tag),
        .hit(ret_hit_w), .idx(ret_idx_w)
    );

    rb_free_pick #(.N(NUM_CKPT), .SLOT_W(SLOT_W)) u_free (
        .vld(st_q.vld), .any_free(free_any_w), .idx(free_idx_w)
    );

    rb_squash_gen #(.AL_DEPTH(AL_DEPTH), .TAG_W(TAG_W)) u_squash (
        .head(al_head), .tail(al_tail), .btag(resolve_tag), .mask(mask_w)
    );

    for (genvar j = 0; j < NUM_CKPT; j++) begin : g_age
        assign younger_w[j] = st_q.vld[j] &&
            rb_is_younger(32'(st_q.tag[j]), 32'(resolve_tag), 32'(al_head), 32'(AL_DEPTH));
    end

    assign alloc_ready = free_any_w;
    assign rb_fire_w   = resolve_valid && resolve_mispred && res_hit_w;

    always_comb begin
        st_d         = st_q;
        st_d.sq_v    = 1'b0;
        st_d.sq_mask = '0;

        if (rb_fire_w) begin
            st_d.sq_v    = 1'b1;
            st_d.sq_mask = mask_w;
            st_d.rs_map  = st_q.map[res_idx_w];
            st_d.rd_pc   = resolve_target;
            st_d.vld     = st_q.vld & ~younger_w;
        end

        if (retire_valid && ret_hit_w) begin
            st_d.vld[ret_idx_w] = 1'b0;
        end

        if (alloc_valid && free_any_w && !rb_fire_w) begin
            st_d.vld[free_idx_w] = 1'b1;
            st_d.tag[free_idx_w] = alloc_tag;
            st_d.map[free_idx_w] = alloc_map;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign squash_valid   = st_q.sq_v;
    assign squash_mask    = st_q.sq_mask;
    assign restore_valid  = st_q.sq_v;
    assign restore_map    = st_q.rs_map;
    assign redirect_valid = st_q.sq_v;
    assign redirect_pc    = st_q.rd_pc;
endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
    parameter int AL_DEPTH = 32,
    parameter int MAP_W    = 48,
    parameter int PC_W     = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        alloc_ready,
    input logic                        resolve_valid,
    input logic                        resolve_mispred,
    input logic [PC_W-1:0]             resolve_target,
    input logic                        retire_valid,
    input logic [$clog2(AL_DEPTH)-1:0] al_head,
    input logic                        squash_valid,
    input logic [AL_DEPTH-1:0]         squash_mask,
    input logic                        restore_valid,
    input logic                        redirect_valid,
    input logic [PC_W-1:0]             redirect_pc
);
    p_squash_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> $past(resolve_valid && resolve_mispred));

    p_idle_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !squash_valid |-> squash_mask == '0);

    p_restore_with_squash_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid == squash_valid);

    p_redirect_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (squash_valid && redirect_pc == $past(resolve_target)));

    p_correct_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && !resolve_mispred) |=> !squash_valid);

    p_head_survives_r9: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> !squash_mask[$past(al_head)]);

    p_stall_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_ready && !retire_valid && !(resolve_valid && resolve_mispred)) |=> !alloc_ready);
endmodule

bind branch_rollback rb_checker #(
    .AL_DEPTH(AL_DEPTH), .MAP_W(MAP_REGS * PREG_W), .PC_W(PC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_ready(alloc_ready),
    .resolve_valid(resolve_valid), .resolve_mispred(resolve_mispred),
    .resolve_target(resolve_target), .retire_valid(retire_valid),
    .al_head(al_head), .squash_valid(squash_valid), .squash_mask(squash_mask),
    .restore_valid(restore_valid), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc)
);

// File: tb/sim_branch_rollback.sv
module sim_branch_rollback;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        alloc_valid;
    logic [4:0]  alloc_tag;
    logic [47:0] alloc_map;
    logic        alloc_ready;
    logic        resolve_valid;
    logic [4:0]  resolve_tag;
    logic        resolve_mispred;
    logic [31:0] resolve_target;
    logic        retire_valid;
    logic [4:0]  retire_tag;
    logic [4:0]  al_head;
    logic [4:0]  al_tail;
    logic        squash_valid;
    logic [31:0] squash_mask;
    logic        restore_valid;
    logic [47:0] restore_map;
    logic        redirect_valid;
    logic [31:0] redirect_pc;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    branch_rollback u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_map(alloc_map),
        .alloc_ready(alloc_ready),
        .resolve_valid(resolve_valid), .resolve_tag(resolve_tag),
        .resolve_mispred(resolve_mispred), .resolve_target(resolve_target),
        .retire_valid(retire_valid), .retire_tag(retire_tag),
        .al_head(al_head), .al_tail(al_tail),
        .squash_valid(squash_valid), .squash_mask(squash_mask),
        .restore_valid(restore_valid), .restore_map(restore_map),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    function automatic logic [47:0] mapval(input int k);
        return {8{6'(k + 1)}} ^ 48'(k * 32'h0001_0203);
    endfunction

    function automatic logic [31:0] exp_mask(input int head, input int tail, input int b);
        logic [31:0] m = '0;
        int ob = (b - head + 32) % 32;
        int ot = (tail - head + 32) % 32;
        for (int i = 0; i < 32; i++) begin
            int oi = (i - head + 32) % 32;
            if (oi > ob && oi < ot) m[i] = 1'b1;
        end
        return m;
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        alloc_valid = 0; alloc_tag = 0; alloc_map = 0;
        resolve_valid = 0; resolve_tag = 0; resolve_mispred = 0; resolve_target = 0;
        retire_valid = 0; retire_tag = 0; al_head = 0; al_tail = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_alloc(input int tag, input logic [47:0] m);
        alloc_valid = 1'b1; alloc_tag = 5'(tag); alloc_map = m;
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic do_resolve(input int tag, input logic mp, input logic [31:0] tgt);
        resolve_valid = 1'b1; resolve_tag = 5'(tag);
        resolve_mispred = mp; resolve_target = tgt;
        @(negedge clk);
        resolve_valid = 1'b0; resolve_mispred = 1'b0;
    endtask

    task automatic do_retire(input int tag);
        retire_valid = 1'b1; retire_tag = 5'(tag);
        @(negedge clk);
        retire_valid = 1'b0;
    endtask

    task automatic expect_rollback(input string req, input int head, input int tail,
                                   input int b, input logic [47:0] m, input logic [31:0] tgt);
        chk(squash_valid === 1'b1, req, "squash_valid", 64'(squash_valid), 64'd1);
        chk(squash_mask === exp_mask(head, tail, b), req, "squash_mask",
            64'(squash_mask), 64'(exp_mask(head, tail, b)));
        chk(restore_valid === 1'b1 && restore_map === m, req, "restore_map",
            64'(restore_map), 64'(m));
        chk(redirect_valid === 1'b1 && redirect_pc === tgt, req, "redirect_pc",
            64'(redirect_pc), 64'(tgt));
    endtask

    task automatic expect_quiet(input string req);
        chk(squash_valid === 1'b0 && restore_valid === 1'b0 && redirect_valid === 1'b0,
            req, "no rollback pulse", 64'(squash_valid), 64'd0);
    endtask

    task automatic t_reset();
        do_reset();
        chk(alloc_ready === 1'b1, "R1", "alloc_ready", 64'(alloc_ready), 64'd1);
        expect_quiet("R1");
        chk(squash_mask === '0, "R1", "squash_mask", 64'(squash_mask), 64'd0);
    endtask

    task automatic t_fill_and_rollback();
        do_reset();
        al_head = 0; al_tail = 16;
        do_alloc(2, mapval(2));
        do_alloc(5, mapval(5));
        do_alloc(9, mapval(9));
        do_alloc(12, mapval(12));
        chk(alloc_ready === 1'b0, "R2", "full stall", 64'(alloc_ready), 64'd0);
        do_alloc(14, mapval(14));
        chk(alloc_ready === 1'b0, "R2", "still full", 64'(alloc_ready), 64'd0);
        do_resolve(5, 1'b1, 32'h1000_0400);
        expect_rollback("R3", 0, 16, 5, mapval(5), 32'h1000_0400);
        chk(alloc_ready === 1'b1, "R7", "younger slots freed", 64'(alloc_ready), 64'd1);
        @(negedge clk);
        expect_quiet("R3");
        do_alloc(6, mapval(6));
        chk(alloc_ready === 1'b1, "R7", "second slot free", 64'(alloc_ready), 64'd1);
        do_alloc(7, mapval(7));
        chk(alloc_ready === 1'b0, "R7", "own slot kept", 64'(alloc_ready), 64'd0);
        do_resolve(14, 1'b1, 32'h2222_0000);
        expect_quiet("R2");
        do_resolve(7, 1'b1, 32'h0000_0abc);
        expect_rollback("R4", 0, 16, 7, mapval(7), 32'h0000_0abc);
    endtask

    task automatic t_correct_prediction();
        do_reset();
        al_head = 1; al_tail = 20;
        do_alloc(3, mapval(3));
        do_alloc(8, mapval(8));
        do_resolve(3, 1'b0, 32'h0bad_0000);
        expect_quiet("R6");
        chk(alloc_ready === 1'b1, "R6", "alloc_ready", 64'(alloc_ready), 64'd1);
        do_resolve(8, 1'b1, 32'h0000_8000);
        expect_rollback("R6", 1, 20, 8, mapval(8), 32'h0000_8000);
        do_resolve(3, 1'b1, 32'h0000_3000);
        expect_rollback("R5", 1, 20, 3, mapval(3), 32'h0000_3000);
    endtask

    task automatic t_retire();
        do_reset();
        al_head = 0; al_tail = 10;
        do_alloc(1, mapval(1));
        do_alloc(2, mapval(2));
        do_alloc(3, mapval(3));
        do_alloc(4, mapval(4));
        chk(alloc_ready === 1'b0, "R8", "full", 64'(alloc_ready), 64'd0);
        do_retire(1);
        al_head = 2;
        chk(alloc_ready === 1'b1, "R8", "freed by retire", 64'(alloc_ready), 64'd1);
        do_resolve(1, 1'b1, 32'h0000_0111);
        expect_quiet("R8");
        do_resolve(2, 1'b1, 32'h0000_0222);
        expect_rollback("R8", 2, 10, 2, mapval(2), 32'h0000_0222);
    endtask

    task automatic t_wrap();
        do_reset();
        al_head = 28; al_tail = 4;
        do_alloc(29, mapval(29));
        do_alloc(30, mapval(30));
        do_alloc(1, mapval(1));
        do_resolve(30, 1'b1, 32'h00ff_0030);
        expect_rollback("R9", 28, 4, 30, mapval(30), 32'h00ff_0030);
        do_resolve(1, 1'b1, 32'h00ff_0001);
        expect_quiet("R9");
        do_resolve(29, 1'b1, 32'h00ff_0029);
        expect_rollback("R9", 28, 4, 29, mapval(29), 32'h00ff_0029);
    endtask

    task automatic t_collide();
        do_reset();
        al_head = 0; al_tail = 12;
        do_alloc(3, mapval(3));
        alloc_valid = 1'b1; alloc_tag = 5'd6; alloc_map = mapval(6);
        do_resolve(3, 1'b1, 32'h0000_0c00);
        alloc_valid = 1'b0;
        expect_rollback("R10", 0, 12, 3, mapval(3), 32'h0000_0c00);
        do_resolve(6, 1'b1, 32'h0000_0600);
        expect_quiet("R10");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_and_rollback();
        t_correct_prediction();
        t_retire();
        t_wrap();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule